// File: doc/BRIEF.md
# SPI Flash Buffered Command Engine

This block is a single-lane SPI master that issues one complete flash command at a time from a small scratch buffer. The host places every outgoing byte in the buffer through a 32-bit register port: opcode, address, dummy bytes and any write payload. It then sets how many bytes go out and how many come back, and sets enable and trigger together in the control word. The engine holds chip select low for the whole command. It shifts the outgoing bytes out most significant bit first, and stores each incoming byte back into the same buffer directly behind the last outgoing one.

Progress is reported by two read-only flags. The ready flag rises as soon as the trigger is accepted. The in-progress flag falls only when the last bit has been clocked. Software then clears trigger and enable to return the engine to idle. The buffer and the byte counts keep their contents between commands, so the host can read the response at its own pace.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock and the serial output are low, and the control word and both byte counts read 0.
- R2: Register word addresses 0 to 39 map the 160-byte buffer, and address 40 holds the outbound count, 41 the inbound count and 42 the control word. Buffer bytes are packed little-endian: buffer byte 4w+k sits in bits 8k+7:8k of word w.
- R3: Control word bits: bit 0 in-progress (read-only), bit 1 ready (read-only), bit 2 trigger, bit 3 enable, bit 4 lane select (stored and read back, no effect on the single-lane engine).
- R4: When enable and trigger are both set in idle, the first control read after the write shows ready=1 and in-progress=1. When the transfer has ended, in-progress reads 0 while ready stays 1.
- R5: A trigger with enable clear starts nothing: chip select stays high, no clock edges occur and ready stays 0.
- R6: SPI mode 0. The clock idles low and is low whenever chip select is high. The output changes only while the clock is low. Each clock period is 2*HALF_DIV system cycles, with no gap between bytes.
- R7: Outbound bytes are sent from buffer byte offsets 0 up to the outbound count minus 1, in that order, each most significant bit first.
- R8: During the inbound phase the serial output is held low. Input bits that arrive during the outbound phase are ignored: buffer bytes below the outbound count are unchanged after the transfer.
- R9: Inbound byte j (first bit received is its bit 7) is stored at buffer byte offset outbound count + j, also when that offset falls mid-word. All other buffer bytes keep their values.
- R10: The outbound count is clipped to 160, and the inbound count to 160 minus the clipped outbound count. Exactly 8 × (clipped sum) clock pulses are produced.
- R11: While trigger or enable stays set after completion, no new transfer starts. Clearing both returns the engine to idle, and ready then reads 0.
- R12: With both counts 0, a trigger produces no clock pulse and chip select stays high. The control read after the write shows ready=1 and in-progress=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check several properties on every cycle. The clock must stay low while chip select is high, and the output must be stable while the clock is high. Chip select may be low only while the in-progress flag is set, and in-progress implies ready. A transfer may begin only after enable and trigger were both set. The byte pointer must stay inside the clipped total, and a finished engine must stay quiet while its control bits are held. Other behaviour can only be shown by the bench's scenarios, which drive a behavioural flash model and compare against a byte image of the buffer. This covers byte order on the wire and where received bytes land, including a mid-word start. It also covers the clipping of oversized counts, the zero-length case and the flag sequence seen by software.

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
  parameter int BUF_BYTES = 160,
  parameter int HALF_DIV  = 2,
  parameter int AW        = 6,
  parameter int CNT_W     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int IW    = $clog2(BUF_BYTES + 1);
  localparam int DW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [AW-1:0] A_OUT = AW'(WORDS);
  localparam logic [AW-1:0] A_IN  = AW'(WORDS + 1);
  localparam logic [AW-1:0] A_CTL = AW'(WORDS + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} st_t;

  logic [7:0]       mem [BUF_BYTES];
  logic [CNT_W-1:0] out_cnt, in_cnt;
  logic             c_trig, c_en, c_lane, f_ready, f_wip;
  st_t              st;
  logic [IW-1:0]    out_e, tot, idx;
  logic [2:0]       bitn;
  logic [DW-1:0]    div;
  logic [7:0]       rx_sh;
  logic [IW-1:0]    out_clip, room, in_clip, hbase;
  logic             is_buf, go, tick, rise, fall, last_bit, last_byte;

  assign is_buf    = reg_addr < AW'(WORDS);
  assign hbase     = IW'({reg_addr, 2'b00});
  assign go        = (st == ST_IDLE) && c_en && c_trig;
  assign tick      = div == DW'(HALF_DIV - 1);
  assign rise      = (st == ST_XFER) && tick && !spi_sck;
  assign fall      = (st == ST_XFER) && tick && spi_sck;
  assign last_bit  = bitn == 3'd7;
  assign last_byte = idx == tot - IW'(1);
  assign spi_mosi  = (st == ST_XFER) && (idx < out_e) && mem[idx][3'd7 - bitn];

  always_comb begin
    out_clip = (out_cnt > CNT_W'(BUF_BYTES)) ? IW'(BUF_BYTES) : out_cnt[IW-1:0];
    room     = IW'(BUF_BYTES) - out_clip;
    in_clip  = (in_cnt > CNT_W'(room)) ? room : in_cnt[IW-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (is_buf) begin
      for (int k = 0; k < 4; k++) reg_rdata[8*k +: 8] = mem[hbase + IW'(k)];
    end else if (reg_addr == A_OUT) begin
      reg_rdata[CNT_W-1:0] = out_cnt;
    end else if (reg_addr == A_IN) begin
      reg_rdata[CNT_W-1:0] = in_cnt;
    end else if (reg_addr == A_CTL) begin
      reg_rdata[4:0] = {c_lane, c_en, c_trig, f_ready, f_wip};
    end
  end

  always_ff @(posedge clk) begin
    if (reg_we && is_buf)
      for (int k = 0; k < 4; k++) mem[hbase + IW'(k)] <= reg_wdata[8*k +: 8];
    if (fall && last_bit && idx >= out_e)
      mem[idx] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
      in_cnt  <= '0;
      c_trig  <= 1'b0;
      c_en    <= 1'b0;
      c_lane  <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == A_OUT) out_cnt <= reg_wdata[CNT_W-1:0];
      if (reg_addr == A_IN)  in_cnt  <= reg_wdata[CNT_W-1:0];
      if (reg_addr == A_CTL) begin
        c_trig <= reg_wdata[2];
        c_en   <= reg_wdata[3];
        c_lane <= reg_wdata[4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      f_ready  <= 1'b0;
      f_wip    <= 1'b0;
      spi_sck  <= 1'b0;
      spi_cs_n <= 1'b1;
      out_e    <= '0;
      tot      <= '0;
      idx      <= '0;
      bitn     <= '0;
      div      <= '0;
      rx_sh    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          f_ready <= 1'b1;
          out_e   <= out_clip;
          tot     <= out_clip + in_clip;
          idx     <= '0;
          bitn    <= '0;
          div     <= '0;
          if (out_clip + in_clip == '0) begin
            st <= ST_DONE;
          end else begin
            st       <= ST_XFER;
            f_wip    <= 1'b1;
            spi_cs_n <= 1'b0;
          end
        end
        ST_XFER: begin
          div <= tick ? '0 : div + DW'(1);
          if (rise) begin
            spi_sck <= 1'b1;
            rx_sh   <= {rx_sh[6:0], spi_miso};
          end
          if (fall) begin
            spi_sck <= 1'b0;
            bitn    <= bitn + 3'd1;
            if (last_bit) begin
              idx <= idx + IW'(1);
              if (last_byte) begin
                spi_cs_n <= 1'b1;
                f_wip    <= 1'b0;
                st       <= ST_DONE;
              end
            end
          end
        end
        default: if (!c_en && !c_trig) begin
          st      <= ST_IDLE;
          f_ready <= 1'b0;
        end
      endcase
    end
  end

  p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));
  p_wip_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    f_wip |-> f_ready);
  p_cs_wip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> f_wip);
  p_start_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(c_en && c_trig));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER) |-> (idx < tot && tot <= IW'(BUF_BYTES)));
  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && (c_en || c_trig)) |=> (spi_cs_n && f_ready));
endmodule

// File: tb/flash_cmd_engine_bench.sv
`timescale 1ns/1ps
module flash_cmd_engine_bench;
  localparam int HALF = 2;
  localparam int NB   = 160;

  logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, spi_miso = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;

  flash_cmd_engine #(.BUF_BYTES(NB), .HALF_DIV(HALF)) u_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_buf [NB];
  logic [7:0] slv [NB];
  int rises = 0, bidx = 0, out_m = 0, cyc = 0, last_rise = 0;
  int mosi_err = 0, rxlow_err = 0, per_err = 0, cs_sck_err = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference flash model and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (spi_cs_n && spi_sck) cs_sck_err++;
    if (prev_cs && !spi_cs_n) bidx = 0;
    if (!prev_sck && spi_sck) begin
      int b, k;
      logic e;
      b = rises;
      k = b / 8;
      e = (k < out_m) ? exp_buf[k][7 - b % 8] : 1'b0;
      if (rises > 0 && cyc - last_rise != 2 * HALF) per_err++;
      last_rise = cyc;
      if (spi_mosi !== e) begin
        if (k < out_m) mosi_err++; else rxlow_err++;
      end
      rises++;
    end
    if (prev_sck && !spi_sck) bidx++;
    spi_miso = (bidx < 8 * NB) ? slv[bidx / 8][7 - bidx % 8] : 1'b0;
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic load_buf();
    for (int w = 0; w < NB / 4; w++)
      wr(w, {exp_buf[4*w+3], exp_buf[4*w+2], exp_buf[4*w+1], exp_buf[4*w]});
  endtask

  task automatic run(input int on, input int in_n);
    logic [31:0] r, d;
    int oe, ie, tot, e_tx, e_rx, r0;
    oe = (on > NB) ? NB : on;
    ie = (in_n > NB - oe) ? NB - oe : in_n;
    tot = oe + ie;
    out_m = oe; rises = 0; mosi_err = 0; rxlow_err = 0; per_err = 0;
    wr(40, on); wr(41, in_n); wr(42, 32'h0000_000C);
    rd(42, r);
    if (tot > 0) chk(r[1:0] == 2'b11, "R4 start flags", r[1:0], 3);
    else         chk(r[1:0] == 2'b10, "R12 zero-length flags", r[1:0], 2);
    for (int i = 0; i < 20000 && r[0]; i++) rd(42, r);
    chk(r[1:0] == 2'b10 && spi_cs_n, "R4 end flags", r[1:0], 2);
    if (tot > 0) chk(rises == 8 * tot, "R10 clock pulses", rises, 8 * tot);
    else         chk(rises == 0, "R12 no clock", rises, 0);
    chk(mosi_err == 0, "R7 outbound bits", mosi_err, 0);
    chk(rxlow_err == 0, "R8 output low while receiving", rxlow_err, 0);
    chk(per_err == 0, "R6 clock period", per_err, 0);
    for (int j = 0; j < ie; j++) exp_buf[oe + j] = slv[oe + j];
    e_tx = 0; e_rx = 0;
    for (int w = 0; w < NB / 4; w++) begin
      rd(w, d);
      for (int k = 0; k < 4; k++)
        if (d[8*k +: 8] !== exp_buf[4*w+k]) begin
          if (4*w+k < oe) e_tx++; else e_rx++;
        end
    end
    chk(e_tx == 0, "R8 outbound bytes untouched", e_tx, 0);
    chk(e_rx == 0, "R9 inbound placement", e_rx, 0);
    r0 = rises;
    repeat (20) @(negedge clk);
    chk(spi_cs_n && rises == r0, "R11 no restart while held", rises, r0);
    wr(42, 0);
    rd(42, r);
    chk(r[1:0] == 2'b00, "R11 idle after clear", r[1:0], 0);
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int k = 0; k < NB; k++) begin
      exp_buf[k] = 8'(k * 13 + 1);
      slv[k]     = 8'(k * 7 + 8'h5A);
    end
    repeat (3) @(negedge clk);
    rd(42, r);
    chk(spi_cs_n && !spi_sck && !spi_mosi && r == 0, "R1 reset outputs", r, 0);
    rst_n = 1'b1;
    rd(40, r); chk(r == 0, "R1 outbound count reset", r, 0);
    rd(41, r); chk(r == 0, "R1 inbound count reset", r, 0);

    wr(3, 32'h4433_2211);
    rd(3, r); chk(r == 32'h4433_2211, "R2 word readback", r, 32'h4433_2211);
    load_buf();
    rd(3, r);
    chk(r == {exp_buf[15], exp_buf[14], exp_buf[13], exp_buf[12]}, "R2 little-endian",
        r, {exp_buf[15], exp_buf[14], exp_buf[13], exp_buf[12]});

    wr(40, 2); wr(41, 2);
    wr(42, 32'h0000_0017);
    rd(42, r); chk(r == 32'h14, "R3 control bits", r, 32'h14);
    rises = 0;
    repeat (30) @(negedge clk);
    rd(42, r);
    chk(spi_cs_n && rises == 0 && r[1] == 1'b0, "R5 trigger without enable", rises, 0);
    wr(42, 0);

    run(0, 0);
    run(5, 6);
    run(1, 4);
    run(3, 0);
    run(150, 30);
    run(200, 50);

    chk(cs_sck_err == 0, "R6 clock low while deselected", cs_sck_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule